// File: doc/BRIEF.md
# Dual-Layout Floating-Point Register File

This block holds the floating-point operand registers of a processor core: a bank of 32 entries, each 64 bits wide, with two combinational read ports and one write port. Every port carries a width select that picks between a 32-bit word access and a 64-bit double access. A word access always works on the low half of one entry.

How a double access is served depends on a layout flag. With the flag set, a double access uses the whole of one entry. With the flag clear, a double value is spread over an even/odd pair of entries. The low half of entry N carries value bits 31:0. The low half of entry N|1 carries bits 63:32. The block does not check whether a register number is legal for the current layout; a separate checker handles that.

The layout flag and an FPU-enable flag are held in a small status word. That word is updated by masked writes, and both flags are refreshed from bit 26 (layout) and bit 29 (enable) of the masked write value. A write to the bank can be read back in the same cycle.

Top module: `fpregfile_mode`

## Requirements
- R1: A synchronous active-high reset clears every register entry, the status word and both flags to zero.
- R2: A status write replaces the status bits whose mask bit is 1 with the write data and keeps every other status bit; the new word is visible from the next cycle.
- R3: On each status write, the layout flag becomes bit 26 of (data AND mask) and the enable flag becomes bit 29 of (data AND mask), from the next cycle; without a status write both flags hold.
- R4: A word access (width select 0) writes only bits 31:0 of the addressed entry and keeps its bits 63:32; a word read returns bits 31:0 of the entry with 63:32 zero.
- R5: With the layout flag set, a double access (width select 1) reads or writes all 64 bits of entry N.
- R6: With the layout flag clear, a double read of an even N returns {low half of entry N|1, low half of entry N}.
- R7: With the layout flag clear, a double write stores data bits 63:32 in the low half of entry N|1 and bits 31:0 in the low half of entry N, leaving the high halves of both entries unchanged.
- R8: With the layout flag clear and N odd, a double write leaves data bits 31:0 in the low half of entry N, and a double read returns that low half in both result halves, with no error indication.
- R9: Reads see a write made in the same cycle (write-to-read bypass), for every width and layout.
- R10: The two read ports are independent and may address any entries, including the same one, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| stat_we | input | 1 | Status write strobe |
| stat_wdata | input | 32 | Status write data |
| stat_wmask | input | 32 | Writable-bit mask for the status write |
| status_o | output | 32 | Current status word |
| fpu_en_o | output | 1 | FPU-enable flag |
| wide_mode_o | output | 1 | Layout flag: 1 = whole-entry doubles, 0 = paired doubles |
| wr_en | input | 1 | Register write strobe |
| wr_dbl | input | 1 | Write width: 0 word, 1 double |
| wr_idx | input | 5 | Write register number |
| wr_data | input | 64 | Write data |
| rd0_idx | input | 5 | Read port 0 register number |
| rd0_dbl | input | 1 | Read port 0 width |
| rd0_data | output | 64 | Read port 0 data |
| rd1_idx | input | 5 | Read port 1 register number |
| rd1_dbl | input | 1 | Read port 1 width |
| rd1_data | output | 64 | Read port 1 data |

## Verification
Some properties are checked on every cycle. These are the masked merge of the status word and the flag update from the masked write value, the holding of the flags and the status word between writes, the zero upper half of word reads, and the same-cycle bypass of a matching write. Two more are also checked every cycle: in paired layout, the high half of a double read must equal a word read of the odd partner made on the other port, and read data must stay stable while no write occurs and the read address does not change. How double values land in entries after a change of layout, and what an odd register number does in paired layout, only show up over a sequence of writes, layout switches and reads. The bench covers these with random traffic and directed sequences.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

    localparam int HALF_W = 32;
    localparam int FULL_W = 64;
    localparam int STAT_W = 32;
    localparam int FR_POS = 26;
    localparam int CU_POS = 29;

    typedef enum logic {
        ACC_WORD = 1'b0,
        ACC_DBL  = 1'b1
    } acc_e;

    typedef struct packed {
        logic fpu_on;
        logic wide;
    } mode_t;

    typedef struct packed {
        logic              en;
        acc_e              width;
        logic [FULL_W-1:0] data;
    } wr_req_t;

    function automatic logic [FULL_W-1:0] compose_pair(
        input logic [FULL_W-1:0] hi_ent,
        input logic [FULL_W-1:0] lo_ent
    );
        return {hi_ent[HALF_W-1:0], lo_ent[HALF_W-1:0]};
    endfunction

    function automatic logic [FULL_W-1:0] word_view(input logic [FULL_W-1:0] ent);
        return {{(FULL_W-HALF_W){1'b0}}, ent[HALF_W-1:0]};
    endfunction

endpackage

// File: rtl/fpr_mode_ctl.sv
module fpr_mode_ctl
    import fpr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wr_data,
    input  logic [STAT_W-1:0] wr_mask,
    output logic [STAT_W-1:0] status_o,
    output mode_t             mode_o
);
    logic [STAT_W-1:0] status_q;
    logic [STAT_W-1:0] masked;
    mode_t             mode_q;

    assign masked = wr_data & wr_mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            mode_q   <= '0;
        end else if (wr_en) begin
            status_q      <= (status_q & ~wr_mask) | masked;
            mode_q.wide   <= masked[FR_POS];
            mode_q.fpu_on <= masked[CU_POS];
        end
    end

    assign status_o = status_q;
    assign mode_o   = mode_q;
endmodule

// File: rtl/fpr_bank.sv
module fpr_bank
    import fpr_pkg::*;
#(
    parameter int NREG  = 32,
    parameter int IDX_W = $clog2(NREG)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wide,
    input  wr_req_t                       wr,
    input  logic [IDX_W-1:0]              wr_idx,
    output logic [NREG-1:0][FULL_W-1:0]   view_o
);
    logic [NREG-1:0][FULL_W-1:0] ent_q;
    logic [NREG-1:0][FULL_W-1:0] ent_nxt;
    logic [IDX_W-1:0]            partner;

    assign partner = wr_idx | IDX_W'(1);

    for (genvar g = 0; g < NREG; g++) begin : g_ent
        localparam logic [IDX_W-1:0] SELF = IDX_W'(g);
        always_comb begin
            ent_nxt[g] = ent_q[g];
            if (wr.en) begin
                if (wr.width == ACC_WORD) begin
                    if (wr_idx == SELF) ent_nxt[g][HALF_W-1:0] = wr.data[HALF_W-1:0];
                end else if (wide) begin
                    if (wr_idx == SELF) ent_nxt[g] = wr.data;
                end else begin
                    if (partner == SELF) ent_nxt[g][HALF_W-1:0] = wr.data[FULL_W-1:HALF_W];
                    if (wr_idx == SELF)  ent_nxt[g][HALF_W-1:0] = wr.data[HALF_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ent_q <= '0;
        else     ent_q <= ent_nxt;
    end

    assign view_o = ent_nxt;
endmodule

// File: rtl/fpr_rdport.sv
module fpr_rdport
    import fpr_pkg::*;
#(
    parameter int NREG  = 32,
    parameter int IDX_W = $clog2(NREG)
) (
    input  logic [NREG-1:0][FULL_W-1:0] view_i,
    input  logic                        wide,
    input  logic [IDX_W-1:0]            idx,
    input  acc_e                        width,
    output logic [FULL_W-1:0]           data_o
);
    logic [IDX_W-1:0] odd_idx;

    assign odd_idx = idx | IDX_W'(1);

    always_comb begin
        if (width == ACC_WORD)  data_o = word_view(view_i[idx]);
        else if (wide)          data_o = view_i[idx];
        else                    data_o = compose_pair(view_i[odd_idx], view_i[idx]);
    end
endmodule

// File: rtl/fpregfile_mode.sv
module fpregfile_mode
    import fpr_pkg::*;
#(
    parameter int NREG  = 32,
    parameter int NRD   = 2,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stat_we,
    input  logic [STAT_W-1:0] stat_wdata,
    input  logic [STAT_W-1:0] stat_wmask,
    output logic [STAT_W-1:0] status_o,
    output logic              fpu_en_o,
    output logic              wide_mode_o,
    input  logic              wr_en,
    input  logic              wr_dbl,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [FULL_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd0_idx,
    input  logic              rd0_dbl,
    output logic [FULL_W-1:0] rd0_data,
    input  logic [IDX_W-1:0]  rd1_idx,
    input  logic              rd1_dbl,
    output logic [FULL_W-1:0] rd1_data
);
    mode_t                       mode;
    wr_req_t                     wreq;
    logic [NREG-1:0][FULL_W-1:0] view;
    logic [NRD-1:0][IDX_W-1:0]   rd_idx;
    logic [NRD-1:0]              rd_dbl;
    logic [NRD-1:0][FULL_W-1:0]  rd_data;

    fpr_mode_ctl u_mode (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (stat_we),
        .wr_data  (stat_wdata),
        .wr_mask  (stat_wmask),
        .status_o (status_o),
        .mode_o   (mode)
    );

    assign wreq.en    = wr_en;
    assign wreq.width = acc_e'(wr_dbl);
    assign wreq.data  = wr_data;

    fpr_bank #(.NREG(NREG), .IDX_W(IDX_W)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .wide   (mode.wide),
        .wr     (wreq),
        .wr_idx (wr_idx),
        .view_o (view)
    );

    assign rd_idx = {rd1_idx, rd0_idx};
    assign rd_dbl = {rd1_dbl, rd0_dbl};

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        fpr_rdport #(.NREG(NREG), .IDX_W(IDX_W)) u_rd (
            .view_i (view),
            .wide   (mode.wide),
            .idx    (rd_idx[p]),
            .width  (acc_e'(rd_dbl[p])),
            .data_o (rd_data[p])
        );
    end

    assign rd0_data    = rd_data[0];
    assign rd1_data    = rd_data[1];
    assign fpu_en_o    = mode.fpu_on;
    assign wide_mode_o = mode.wide;
endmodule

// File: rtl/fpr_rf_chk.sv
module fpr_rf_chk
    import fpr_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              stat_we,
    input logic [STAT_W-1:0] stat_wdata,
    input logic [STAT_W-1:0] stat_wmask,
    input logic [STAT_W-1:0] status_o,
    input logic              fpu_en_o,
    input logic              wide_mode_o,
    input logic              wr_en,
    input logic              wr_dbl,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [FULL_W-1:0] wr_data,
    input logic [IDX_W-1:0]  rd0_idx,
    input logic              rd0_dbl,
    input logic [FULL_W-1:0] rd0_data,
    input logic [IDX_W-1:0]  rd1_idx,
    input logic              rd1_dbl,
    input logic [FULL_W-1:0] rd1_data
);
    logic rst_q = 1'b0;
    logic live  = 1'b0;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        live  <= !rst;
        // R1
        if (rst_q) begin
            reset_clear_chk: assert (status_o == '0 && !fpu_en_o && !wide_mode_o);
        end
    end

    // R2
    status_merge_chk: assert property (@(posedge clk) disable iff (rst)
        stat_we |=> status_o == (($past(status_o) & ~$past(stat_wmask)) |
                                 ($past(stat_wdata) & $past(stat_wmask))));

    // R3
    flag_update_chk: assert property (@(posedge clk) disable iff (rst)
        stat_we |=> (wide_mode_o == $past(stat_wdata[FR_POS] & stat_wmask[FR_POS])) &&
                    (fpu_en_o == $past(stat_wdata[CU_POS] & stat_wmask[CU_POS])));

    // R3
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !stat_we |=> $stable(wide_mode_o) && $stable(fpu_en_o) && $stable(status_o));

    // R4
    word_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rd1_dbl |-> rd1_data[FULL_W-1:HALF_W] == '0);

    // R9
    word_bypass_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_dbl && !rd0_dbl && rd0_idx == wr_idx) |->
            rd0_data[HALF_W-1:0] == wr_data[HALF_W-1:0]);

    // R5
    wide_bypass_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_dbl && wide_mode_o && rd0_dbl && rd0_idx == wr_idx) |->
            rd0_data == wr_data);

    // R6
    pair_high_chk: assert property (@(posedge clk) disable iff (rst)
        (rd0_dbl && !wide_mode_o && !rd1_dbl && rd1_idx == (rd0_idx | IDX_W'(1))) |->
            rd0_data[FULL_W-1:HALF_W] == rd1_data[HALF_W-1:0]);

    // R10
    read_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (live && !wr_en && !stat_we && $past(!wr_en && !stat_we) &&
         $stable(rd0_idx) && $stable(rd0_dbl)) |-> $stable(rd0_data));
endmodule

bind fpregfile_mode fpr_rf_chk #(.IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .stat_we     (stat_we),
    .stat_wdata  (stat_wdata),
    .stat_wmask  (stat_wmask),
    .status_o    (status_o),
    .fpu_en_o    (fpu_en_o),
    .wide_mode_o (wide_mode_o),
    .wr_en       (wr_en),
    .wr_dbl      (wr_dbl),
    .wr_idx      (wr_idx),
    .wr_data     (wr_data),
    .rd0_idx     (rd0_idx),
    .rd0_dbl     (rd0_dbl),
    .rd0_data    (rd0_data),
    .rd1_idx     (rd1_idx),
    .rd1_dbl     (rd1_dbl),
    .rd1_data    (rd1_data)
);

// File: tb/test_fpregfile_mode.sv
module test_fpregfile_mode;
    localparam int CLK_P = 10;
    localparam int FRB   = 26;
    localparam int CUB   = 29;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stat_we = 1'b0;
    logic [31:0] stat_wdata = '0;
    logic [31:0] stat_wmask = '0;
    logic [31:0] status_o;
    logic        fpu_en_o, wide_mode_o;
    logic        wr_en = 1'b0, wr_dbl = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic [63:0] wr_data = '0;
    logic [4:0]  rd0_idx = '0, rd1_idx = '0;
    logic        rd0_dbl = 1'b0, rd1_dbl = 1'b0;
    logic [63:0] rd0_data, rd1_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [63:0] m_reg [32];
    logic [63:0] v     [32];
    logic [31:0] m_stat;
    logic        m_wide, m_fpu;

    always #(CLK_P/2) clk = ~clk;

    fpregfile_mode i_fpregfile_mode (
        .clk(clk), .rst(rst),
        .stat_we(stat_we), .stat_wdata(stat_wdata), .stat_wmask(stat_wmask),
        .status_o(status_o), .fpu_en_o(fpu_en_o), .wide_mode_o(wide_mode_o),
        .wr_en(wr_en), .wr_dbl(wr_dbl), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd0_idx(rd0_idx), .rd0_dbl(rd0_dbl), .rd0_data(rd0_data),
        .rd1_idx(rd1_idx), .rd1_dbl(rd1_dbl), .rd1_data(rd1_data)
    );

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_read(input logic [4:0] idx, input logic dbl);
        if (!dbl)        return {32'h0, v[idx][31:0]};
        else if (m_wide) return v[idx];
        else             return {v[idx | 5'd1][31:0], v[idx][31:0]};
    endfunction

    function automatic string auto_tag(input logic [4:0] idx, input logic dbl,
                                       input logic we, input logic [4:0] wi);
        if (we && (idx == wi || (!m_wide && (idx | 5'd1) == (wi | 5'd1)))) return "R9";
        if (!dbl)    return "R4";
        if (m_wide)  return "R5";
        if (idx[0])  return "R8";
        return "R6";
    endfunction

    task automatic model_clear();
        for (int k = 0; k < 32; k++) m_reg[k] = '0;
        m_stat = '0; m_wide = 1'b0; m_fpu = 1'b0;
    endtask

    task automatic step(input logic swe, input logic [31:0] sd, input logic [31:0] sm,
                        input logic we, input logic wdbl, input logic [4:0] wi,
                        input logic [63:0] wd,
                        input logic [4:0] r0, input logic r0d,
                        input logic [4:0] r1, input logic r1d, input string tag);
        @(negedge clk);
        stat_we = swe; stat_wdata = sd; stat_wmask = sm;
        wr_en = we; wr_dbl = wdbl; wr_idx = wi; wr_data = wd;
        rd0_idx = r0; rd0_dbl = r0d; rd1_idx = r1; rd1_dbl = r1d;
        #1;
        for (int k = 0; k < 32; k++) v[k] = m_reg[k];
        if (we) begin
            if (!wdbl)       v[wi][31:0] = wd[31:0];
            else if (m_wide) v[wi] = wd;
            else begin
                v[wi | 5'd1][31:0] = wd[63:32];
                v[wi][31:0]        = wd[31:0];
            end
        end
        check(rd0_data, exp_read(r0, r0d), (tag == "") ? auto_tag(r0, r0d, we, wi) : tag);
        check(rd1_data, exp_read(r1, r1d), (tag == "") ? {auto_tag(r1, r1d, we, wi), "/R10"} : tag);
        check({32'h0, status_o}, {32'h0, m_stat}, "R2 status");
        check({62'h0, wide_mode_o, fpu_en_o}, {62'h0, m_wide, m_fpu}, "R3 flags");
        @(posedge clk);
        for (int k = 0; k < 32; k++) m_reg[k] = v[k];
        if (swe) begin
            m_stat = (m_stat & ~sm) | (sd & sm);
            m_wide = sd[FRB] & sm[FRB];
            m_fpu  = sd[CUB] & sm[CUB];
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; stat_we = 1'b0; wr_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_clear();
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        model_clear();
        do_reset();
        // R1: reset state everywhere
        step(0, 0, 0, 0, 0, 0, 0, 5'd0, 1, 5'd31, 0, "R1");
        step(0, 0, 0, 0, 0, 0, 0, 5'd17, 1, 5'd8, 1, "R1");

        // R3: enable whole-entry layout and FPU flag
        step(1, 32'h2400_0000, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0, 0, 0, "R3");
        // R5: whole-entry double write, read back next cycle
        step(0, 0, 0, 1, 1, 5'd4, 64'hA1A2_A3A4_B1B2_B3B4, 5'd4, 1, 5'd5, 1, "R5");
        step(0, 0, 0, 0, 0, 0, 0, 5'd4, 1, 5'd5, 0, "R5");
        // R4: word write keeps upper half
        step(0, 0, 0, 1, 0, 5'd4, 64'hFFFF_FFFF_0000_1111, 5'd3, 1, 5'd3, 0, "");
        step(0, 0, 0, 0, 0, 0, 0, 5'd4, 1, 5'd4, 0, "R4");
        // R2/R3: mask excludes layout bit -> layout flag cleared by masked value
        step(1, 32'hFFFF_FFFF, 32'h0000_00F0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 0, 0, 0, 5'd4, 1, 5'd4, 0, "R6");
        // R7: paired double write to 6/7, high halves untouched
        step(0, 0, 0, 1, 0, 5'd7, 64'h0, 0, 0, 0, 0, "");
        step(1, 32'h0400_0000, 32'h0400_0000, 1, 1, 5'd7, 64'h7777_7777_7070_7070, 0, 0, 0, 0, "");
        step(0, 0, 0, 1, 1, 5'd6, 64'hCAFE_0001_BEEF_0002, 5'd6, 1, 5'd7, 1, "R5");
        step(1, 32'h0, 32'h0400_0000, 0, 0, 0, 0, 0, 0, 0, 0, "R3");
        step(0, 0, 0, 1, 1, 5'd6, 64'h1234_5678_9ABC_DEF0, 5'd6, 1, 5'd7, 0, "R7");
        step(1, 32'h0400_0000, 32'h0400_0000, 0, 0, 0, 0, 0, 0, 0, 0, "R3");
        step(0, 0, 0, 0, 0, 0, 0, 5'd6, 1, 5'd7, 1, "R7");
        step(1, 32'h0, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
        // R8: odd number in paired layout
        step(0, 0, 0, 1, 1, 5'd9, 64'hDEAD_0000_0000_BEEF, 5'd8, 1, 5'd9, 1, "R8");
        step(0, 0, 0, 0, 0, 0, 0, 5'd9, 1, 5'd8, 1, "R8");
        // R9: same-cycle bypass onto both ports
        step(0, 0, 0, 1, 1, 5'd10, 64'h5555_AAAA_3333_CCCC, 5'd10, 1, 5'd11, 0, "R9");

        for (int n = 0; n < 1500; n++) begin
            logic        swe;
            logic [4:0]  wi;
            swe = ($urandom % 10) == 0;
            wi  = 5'($urandom);
            step(swe, $urandom, ($urandom % 2) ? 32'hFFFF_FFFF : $urandom,
                 ($urandom % 4) != 0, 1'($urandom), wi, {$urandom, $urandom},
                 ($urandom % 3 == 0) ? wi : 5'($urandom), 1'($urandom),
                 ($urandom % 3 == 0) ? (wi ^ 5'd1) : 5'($urandom), 1'($urandom), "");
            if (n == 700) begin
                do_reset();
                step(0, 0, 0, 0, 0, 0, 0, 5'd0, 1, 5'd1, 1, "R1");
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule